// File: doc/BRIEF.md
# Dual-Mode Raster Fetch Controller

This block feeds a raster display with pixels taken from one of two frame buffers. A one-bit-per-pixel picture is read in 32-bit words from an on-chip block RAM. An 8- or 16-bit-per-pixel picture is read in 128-bit (16-byte) words from external memory. Both fetch paths run side by side all the time. A control bit picks which of the two reaches the pixel output. Each buffer has its own base register, so software can move either picture anywhere in the 24-bit byte address space. The on-chip buffer is meant to be about 160 KB, which holds a 1440x900 one-bit image. The external buffer lies in a 15.75 MB region and its base must sit on a 16-byte boundary.

A sync generator supplies two signals. `vsync_in` is a level whose rising edge starts a frame. `pix_en` is high in every cycle that needs an active pixel. At each frame start the block loads the pending register values, empties its prefetch buffers and restarts both fetch addresses at their bases. Each address then steps linearly, driven only by the pixels consumed. A request on the external port is a byte address, carried by `mem_req` and accepted in a cycle that also has `mem_ack`. A request that has not been accepted may be withdrawn. Read data returns in request order on `mem_rvalid`. The block RAM answers a read one cycle after `bram_rd`.

Top module: `disp_fetch_top`

## Requirements
- R1: After reset and until the first rising edge of `vsync_in`, `pix_valid`, `bram_rd` and `mem_req` stay low, and `pix_en` has no effect.
- R2: `vsync_evt` goes high for exactly one cycle. That cycle follows the cycle in which `vsync_in` is first sampled high. Holding `vsync_in` high does not raise it again.
- R3: The register map is: `reg_addr` 0 is control (bit 0 = 1 selects color, bit 1 = 1 selects 16 bpp), 1 is the mono base and 2 is the color base. A write applies from the frame that starts at the next rising edge of `vsync_in`. A write in the same cycle as that edge applies one frame later.
- R4: In mono mode, block RAM reads start at the mono base with bits 1:0 cleared and step by 4 bytes per read. Pixel n of a frame is bit (n mod 32) of word n/32, and `pix_data` = {15'b0, bit}.
- R5: In 8 bpp color mode, pixel n is bits [8j+7:8j], with j = n mod 16, of the word at (color base with bits 3:0 cleared) + 16*(n/16). The upper 8 bits of `pix_data` are zero.
- R6: In 16 bpp color mode, pixel n is bits [16j+15:16j], with j = n mod 8, of the word at the aligned color base + 16*(n/8).
- R7: External requests start at the aligned color base and step by 16 per accepted request (`mem_req` and `mem_ack` both high). Buffered words plus outstanding requests never exceed the prefetch depth (default 2). So at acceptance, accepted requests minus fully consumed words in the frame is below that depth.
- R8: `pix_valid` is high exactly in the cycle after each in-frame `pix_en` cycle. The control bit selects which path's pixel appears on `pix_data`.
- R9: Responses to requests accepted before a frame start are discarded. The new frame's pixels come from the new base only.
- R10: The pixel stream and both fetch addresses advance only on `pix_en` cycles, so idle gaps of any length skip no pixel.
- R11: A write to `reg_addr` 3 changes no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select |
| reg_wdata | input | 24 | Register write data |
| vsync_in | input | 1 | Vertical sync level; a rising edge starts a frame |
| pix_en | input | 1 | Active pixel requested this cycle |
| bram_rd | output | 1 | Block RAM read strobe |
| bram_addr | output | 24 | Block RAM byte address (word aligned) |
| bram_rdata | input | 32 | Block RAM data, one cycle after `bram_rd` |
| mem_req | output | 1 | External read request |
| mem_ack | input | 1 | Request accepted when high together with `mem_req` |
| mem_addr | output | 24 | External byte address (16-byte aligned) |
| mem_rvalid | input | 1 | External read data valid |
| mem_rdata | input | 128 | External read data, in request order |
| pix_valid | output | 1 | Pixel output valid |
| pix_data | output | 16 | Pixel value |
| vsync_evt | output | 1 | One-cycle frame-start event |

## Verification
A wrong word count in either prefetch buffer has two visible effects. It either drives an extra external request past the depth bound, or it puts a stale word on `pix_data`. The first shows at the very next acceptance, the second at the next pixel taken from that word. A wrong lane index corrupts a pixel within one `pix_en` cycle. A drifting fetch address shows on the next accepted request or BRAM read. If stale responses are not discarded after a frame start, the first pixels of the new frame carry the old frame's data. If the shadow registers leak early, the mode or base changes in mid-frame and the next pixel compare fails.

// File: rtl/dfc_pkg.sv
package dfc_pkg;
  localparam int ADDR_W  = 24;
  localparam int MONO_W  = 32;
  localparam int COLOR_W = 128;
  localparam int PIX_W   = 16;
  localparam int MIDX_W  = $clog2(MONO_W);
  localparam int CIDX_W  = $clog2(COLOR_W / 8);

  typedef logic [ADDR_W-1:0] addr_t;

  typedef enum logic [1:0] {
    SEL_CTRL       = 2'd0,
    SEL_MONO_BASE  = 2'd1,
    SEL_COLOR_BASE = 2'd2,
    SEL_SPARE      = 2'd3
  } reg_sel_e;

  typedef struct packed {
    logic wide;       // 16 bpp when set, else 8 bpp
    logic color_sel;  // color path drives the output when set
  } mode_t;

  function automatic addr_t align_down(addr_t a, int unsigned bytes);
    return a & ~addr_t'(bytes - 1);
  endfunction

  function automatic logic [PIX_W-1:0] color_pick(logic [COLOR_W-1:0] w,
                                                  logic [CIDX_W-1:0] idx,
                                                  logic wide);
    logic [PIX_W-1:0] r;
    if (wide) r = w[idx[CIDX_W-2:0]*16 +: 16];
    else      r = {8'h00, w[idx*8 +: 8]};
    return r;
  endfunction

  function automatic logic color_last(logic [CIDX_W-1:0] idx, logic wide);
    return wide ? (idx[CIDX_W-2:0] == '1) : (idx == '1);
  endfunction

  function automatic logic mono_pick(logic [MONO_W-1:0] w, logic [MIDX_W-1:0] idx);
    return w[idx];
  endfunction
endpackage

// File: rtl/dfc_fifo.sv
module dfc_fifo #(
  parameter int W     = 32,
  parameter int DEPTH = 2,
  localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          flush,
  input  logic          push,
  input  logic [W-1:0]  din,
  input  logic          pop,
  output logic [W-1:0]  dout,
  output logic [CW-1:0] cnt
);
  logic [W-1:0]  mem [DEPTH];
  logic [PW-1:0] wr_q, rd_q;
  logic [CW-1:0] cnt_q;

  function automatic logic [PW-1:0] bump(logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else if (flush) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (push) wr_q <= bump(wr_q);
      if (pop)  rd_q <= bump(rd_q);
      cnt_q <= cnt_q + CW'(push) - CW'(pop);
    end
  end

  always_ff @(posedge clk) begin
    if (push && !flush) mem[wr_q] <= din;
  end

  assign dout = mem[rd_q];
  assign cnt  = cnt_q;

  // R7: a word is never written into a full buffer
  a_r7_fifo_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    (push && !pop && !flush) |-> (cnt_q < CW'(DEPTH)));
  // R7: a word is never taken from an empty buffer
  a_r7_fifo_no_underflow: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && !flush) |-> (cnt_q != '0));
endmodule

// File: rtl/dfc_regs.sv
module dfc_regs import dfc_pkg::*; #(
  parameter addr_t MONO_BASE_RST = 24'hE0_0000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       reg_we,
  input  logic [1:0] reg_addr,
  input  addr_t      reg_wdata,
  input  logic       frame_start,
  output addr_t      pend_mono_base,
  output addr_t      pend_color_base,
  output mode_t      act_mode
);
  mode_t pend_mode;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_mode       <= '0;
      pend_mono_base  <= MONO_BASE_RST;
      pend_color_base <= '0;
    end else if (reg_we) begin
      case (reg_sel_e'(reg_addr))
        SEL_CTRL:       pend_mode <= '{wide: reg_wdata[1], color_sel: reg_wdata[0]};
        SEL_MONO_BASE:  pend_mono_base  <= reg_wdata;
        SEL_COLOR_BASE: pend_color_base <= reg_wdata;
        default: ;
      endcase
    end
  end

  // Bases take effect through the fetch counters, which load them at frame start.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           act_mode <= '0;
    else if (frame_start) act_mode <= pend_mode;
  end

  a_r3_mode_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_start |=> $stable(act_mode));
  a_r3_mode_load: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |=> (act_mode == $past(pend_mode)));
endmodule

// File: rtl/dfc_mono_path.sv
module dfc_mono_path import dfc_pkg::*; #(
  parameter int DEPTH = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frame_start,
  input  logic              running,
  input  addr_t             base,
  input  logic              take,
  output logic              bram_rd,
  output addr_t             bram_addr,
  input  logic [MONO_W-1:0] bram_rdata,
  output logic              pix_bit
);
  localparam int CW   = $clog2(DEPTH + 1);
  localparam int SW   = CW + 1;
  localparam int STEP = MONO_W / 8;

  addr_t              addr_q;
  logic               inflight_q;
  logic [MIDX_W-1:0]  idx_q;
  logic [CW-1:0]      cnt;
  logic [MONO_W-1:0]  head;
  logic [SW-1:0]      occ;
  logic               push, pop, empty, word_done;

  assign empty     = (cnt == '0);
  assign occ       = {1'b0, cnt} + SW'(inflight_q);
  assign bram_rd   = running & ~frame_start & (occ < SW'(DEPTH));
  assign bram_addr = addr_q;
  assign push      = inflight_q & ~frame_start;
  assign word_done = take & (idx_q == MIDX_W'(MONO_W - 1));
  assign pop       = word_done & ~empty;
  assign pix_bit   = mono_pick(head, idx_q) & ~empty;

  dfc_fifo #(.W(MONO_W), .DEPTH(DEPTH)) u_buf (
    .clk(clk), .rst_n(rst_n), .flush(frame_start),
    .push(push), .din(bram_rdata), .pop(pop), .dout(head), .cnt(cnt)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q     <= '0;
      inflight_q <= 1'b0;
      idx_q      <= '0;
    end else begin
      inflight_q <= bram_rd;
      if (frame_start) begin
        addr_q <= align_down(base, STEP);
        idx_q  <= '0;
      end else begin
        if (bram_rd) addr_q <= addr_q + ADDR_W'(STEP);
        if (take)    idx_q  <= idx_q + 1'b1;
      end
    end
  end

  // R4: consecutive reads walk linearly through the buffer
  a_r4_addr_step: assert property (@(posedge clk) disable iff (!rst_n)
    bram_rd |=> (bram_addr == $past(bram_addr) + ADDR_W'(STEP)));
  // R4: reads in flight plus buffered words stay within the buffer
  a_r4_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    occ <= SW'(DEPTH));
endmodule

// File: rtl/dfc_color_path.sv
module dfc_color_path import dfc_pkg::*; #(
  parameter int DEPTH = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               frame_start,
  input  logic               running,
  input  addr_t              base,
  input  logic               wide,
  input  logic               take,
  output logic               mem_req,
  input  logic               mem_ack,
  output addr_t              mem_addr,
  input  logic               mem_rvalid,
  input  logic [COLOR_W-1:0] mem_rdata,
  output logic [PIX_W-1:0]   pix
);
  localparam int CW   = $clog2(DEPTH + 1);
  localparam int OW   = $clog2(2 * DEPTH + 1);
  localparam int SW   = OW + 1;
  localparam int STEP = COLOR_W / 8;

  addr_t              addr_q;
  logic [CIDX_W-1:0]  idx_q;
  logic [OW-1:0]      owed_q, drop_q, owed_n, live;
  logic [CW-1:0]      cnt;
  logic [COLOR_W-1:0] head;
  logic [SW-1:0]      occ;
  logic               accept, discard, push, pop, empty, word_done;

  assign live      = owed_q - drop_q;
  assign occ       = {{(SW-CW){1'b0}}, cnt} + {1'b0, live};
  assign mem_req   = running & ~frame_start & (occ < SW'(DEPTH))
                   & (owed_q < OW'(2 * DEPTH));
  assign mem_addr  = addr_q;
  assign accept    = mem_req & mem_ack;
  assign discard   = mem_rvalid & (drop_q != '0);
  assign push      = mem_rvalid & ~discard & ~frame_start;
  assign owed_n    = owed_q + OW'(accept) - OW'(mem_rvalid);
  assign empty     = (cnt == '0);
  assign word_done = take & color_last(idx_q, wide);
  assign pop       = word_done & ~empty;
  assign pix       = empty ? '0 : color_pick(head, idx_q, wide);

  dfc_fifo #(.W(COLOR_W), .DEPTH(DEPTH)) u_buf (
    .clk(clk), .rst_n(rst_n), .flush(frame_start),
    .push(push), .din(mem_rdata), .pop(pop), .dout(head), .cnt(cnt)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      idx_q  <= '0;
      owed_q <= '0;
      drop_q <= '0;
    end else begin
      owed_q <= owed_n;
      if (frame_start) begin
        addr_q <= align_down(base, STEP);
        idx_q  <= '0;
        drop_q <= owed_n;
      end else begin
        if (accept)  addr_q <= addr_q + ADDR_W'(STEP);
        if (take)    idx_q  <= word_done ? '0 : idx_q + 1'b1;
        if (discard) drop_q <= drop_q - 1'b1;
      end
    end
  end

  // R7: buffered words plus live requests never exceed the prefetch depth
  a_r7_occupancy: assert property (@(posedge clk) disable iff (!rst_n)
    occ <= SW'(DEPTH));
  // R7: each accepted request moves the address one word on
  a_r7_addr_step: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> (mem_addr == $past(mem_addr) + ADDR_W'(STEP)));
  // R9: stale responses to drop are always a subset of those still owed
  a_r9_drop_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    drop_q <= owed_q);
endmodule

// File: rtl/disp_fetch_top.sv
module disp_fetch_top import dfc_pkg::*; #(
  parameter int    MONO_DEPTH    = 2,
  parameter int    COLOR_DEPTH   = 2,
  parameter addr_t MONO_BASE_RST = 24'hE0_0000
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               reg_we,
  input  logic [1:0]         reg_addr,
  input  logic [ADDR_W-1:0]  reg_wdata,
  input  logic               vsync_in,
  input  logic               pix_en,
  output logic               bram_rd,
  output logic [ADDR_W-1:0]  bram_addr,
  input  logic [MONO_W-1:0]  bram_rdata,
  output logic               mem_req,
  input  logic               mem_ack,
  output logic [ADDR_W-1:0]  mem_addr,
  input  logic               mem_rvalid,
  input  logic [COLOR_W-1:0] mem_rdata,
  output logic               pix_valid,
  output logic [PIX_W-1:0]   pix_data,
  output logic               vsync_evt
);
  logic             vsync_q, running_q, frame_start, take, mono_bit;
  mode_t            act_mode;
  addr_t            pend_mono_base, pend_color_base;
  logic [PIX_W-1:0] color_pix;

  assign frame_start = vsync_in & ~vsync_q;
  assign take        = pix_en & running_q & ~frame_start;

  dfc_regs #(.MONO_BASE_RST(MONO_BASE_RST)) u_regs (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .frame_start(frame_start),
    .pend_mono_base(pend_mono_base), .pend_color_base(pend_color_base),
    .act_mode(act_mode)
  );

  dfc_mono_path #(.DEPTH(MONO_DEPTH)) u_mono (
    .clk(clk), .rst_n(rst_n), .frame_start(frame_start), .running(running_q),
    .base(pend_mono_base), .take(take), .bram_rd(bram_rd),
    .bram_addr(bram_addr), .bram_rdata(bram_rdata), .pix_bit(mono_bit)
  );

  dfc_color_path #(.DEPTH(COLOR_DEPTH)) u_color (
    .clk(clk), .rst_n(rst_n), .frame_start(frame_start), .running(running_q),
    .base(pend_color_base), .wide(act_mode.wide), .take(take),
    .mem_req(mem_req), .mem_ack(mem_ack), .mem_addr(mem_addr),
    .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata), .pix(color_pix)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vsync_q   <= 1'b0;
      running_q <= 1'b0;
      vsync_evt <= 1'b0;
      pix_valid <= 1'b0;
      pix_data  <= '0;
    end else begin
      vsync_q   <= vsync_in;
      vsync_evt <= frame_start;
      pix_valid <= take;
      if (frame_start) running_q <= 1'b1;
      if (take) pix_data <= act_mode.color_sel ? color_pix : PIX_W'(mono_bit);
      else      pix_data <= '0;
    end
  end

  // R1: no fetch traffic before the first frame
  a_r1_quiet_before_frame: assert property (@(posedge clk) disable iff (!rst_n)
    !running_q |-> (!mem_req && !bram_rd));
  // R2: frame event lasts a single cycle
  a_r2_evt_single: assert property (@(posedge clk) disable iff (!rst_n)
    vsync_evt |=> !vsync_evt);
  // R8: every output pixel answers a pixel request of the previous cycle
  a_r8_valid_follows_en: assert property (@(posedge clk) disable iff (!rst_n)
    pix_valid |-> $past(pix_en));
endmodule

// File: tb/disp_fetch_top_tb_top.sv
`timescale 1ns/1ps
module disp_fetch_top_tb_top;
  localparam int DEPTH = 2;
  localparam int LAT   = 3;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         reg_we = 1'b0;
  logic [1:0]   reg_addr = '0;
  logic [23:0]  reg_wdata = '0;
  logic         vsync_in = 1'b0, pix_en = 1'b0;
  logic         bram_rd, mem_req, pix_valid, vsync_evt;
  logic [23:0]  bram_addr, mem_addr;
  logic [31:0]  bram_rdata = '0;
  logic         mem_ack = 1'b0, mem_rvalid = 1'b0;
  logic [127:0] mem_rdata = '0;
  logic [15:0]  pix_data;

  always #2 clk = ~clk;

  disp_fetch_top dut_i (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .vsync_in(vsync_in), .pix_en(pix_en),
    .bram_rd(bram_rd), .bram_addr(bram_addr), .bram_rdata(bram_rdata),
    .mem_req(mem_req), .mem_ack(mem_ack), .mem_addr(mem_addr),
    .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata),
    .pix_valid(pix_valid), .pix_data(pix_data), .vsync_evt(vsync_evt)
  );

  int n_chk = 0, n_bad = 0;
  bit done = 0;
  // bench model of the register file (R3)
  bit sh_sel = 0, sh_b16 = 0;
  logic [23:0] sh_mb = 24'hE0_0000, sh_cb = 24'h0;
  bit ac_sel = 0, ac_b16 = 0;
  logic [23:0] mb_al = '0, cb_al = '0;
  int k = 0, acc_c = 0, acc_m = 0;
  bit started = 0, vs_prev = 0, pv_exp = 0, ev_exp = 0;
  logic [15:0] pd_exp = '0;
  bit last_rd = 0, last_acc = 0;
  logic [23:0] last_addr = '0, last_acc_addr = '0;
  bit          pipe_v [LAT];
  logic [23:0] pipe_a [LAT];
  string cur_tag = "R4";

  function automatic logic [31:0] mword(logic [23:0] a);
    return ({8'h00, a} * 32'h2C1B_3C6D) ^ 32'hA5A5_F00F ^ {a[7:0], a};
  endfunction

  function automatic logic [127:0] cword(logic [23:0] a);
    logic [127:0] r;
    for (int i = 0; i < 4; i++)
      r[32*i +: 32] = ({8'h00, a} * 32'h9E37_79B1) ^ (32'(i) * 32'h85EB_CA6B) ^ {a[7:0], a};
    return r;
  endfunction

  function automatic logic [15:0] exp_pix(int n);
    logic [127:0] w;
    logic [31:0]  m;
    if (ac_sel && ac_b16) begin
      w = cword(cb_al + 24'(16 * (n / 8)));
      return 16'((w >> (16 * (n % 8))) & 128'hFFFF);
    end else if (ac_sel) begin
      w = cword(cb_al + 24'(16 * (n / 16)));
      return 16'((w >> (8 * (n % 16))) & 128'hFF);
    end
    m = mword(mb_al + 24'(4 * (n / 32)));
    return {15'b0, m[n % 32]};
  endfunction

  task automatic check(string tag, string what, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h (pixel %0d)", tag, what, act, exp, k);
    end
  endtask

  task automatic step(bit vs, bit pe, bit we, logic [1:0] wa, logic [23:0] wd);
    bit rise;
    @(negedge clk);
    if (!started) begin
      check("R1", "pix_valid idle", 32'(pix_valid), 0);
      check("R1", "mem_req idle", 32'(mem_req), 0);
      check("R1", "bram_rd idle", 32'(bram_rd), 0);
    end
    check("R8", "pix_valid", 32'(pix_valid), 32'(pv_exp));
    if (pv_exp) check(cur_tag, "pix_data", 32'(pix_data), 32'(pd_exp));
    check("R2", "vsync_evt", 32'(vsync_evt), 32'(ev_exp));
    // memory models
    bram_rdata = last_rd ? mword(last_addr) : $urandom;
    for (int i = LAT - 1; i > 0; i--) begin
      pipe_v[i] = pipe_v[i-1];
      pipe_a[i] = pipe_a[i-1];
    end
    pipe_v[0] = last_acc;
    pipe_a[0] = last_acc_addr;
    mem_rvalid = pipe_v[LAT-1];
    mem_rdata  = pipe_v[LAT-1] ? cword(pipe_a[LAT-1]) : {4{$urandom}};
    // stimulus
    rise = vs && !vs_prev;
    vsync_in = vs; pix_en = pe; reg_we = we; reg_addr = wa; reg_wdata = wd;
    mem_ack = ($urandom % 4) != 0;
    if (rise) begin
      ac_sel = sh_sel; ac_b16 = sh_b16;
      cb_al = sh_cb & ~24'hF; mb_al = sh_mb & ~24'h3;
      k = 0; acc_c = 0; acc_m = 0; started = 1;
    end
    if (we) begin
      case (wa)
        2'd0: begin sh_sel = wd[0]; sh_b16 = wd[1]; end
        2'd1: sh_mb = wd;
        2'd2: sh_cb = wd;
        default: ;  // R11: no state behind this select
      endcase
    end
    #1;
    last_acc = mem_req && mem_ack;
    last_acc_addr = mem_addr;
    if (last_acc) begin
      check("R7", "mem_addr", 32'(mem_addr), 32'(cb_al + 24'(16 * acc_c)));
      check("R7", "prefetch bound", 32'((acc_c - k / (ac_b16 ? 8 : 16)) < DEPTH), 1);
      acc_c++;
    end
    if (bram_rd) begin
      check("R4", "bram_addr", 32'(bram_addr), 32'(mb_al + 24'(4 * acc_m)));
      acc_m++;
    end
    last_rd = bram_rd;
    last_addr = bram_addr;
    ev_exp = rise;
    pv_exp = pe && started && !rise;
    if (pv_exp) begin
      pd_exp = exp_pix(k);
      k++;
    end
    vs_prev = vs;
  endtask

  // mode: bit0 color, bit1 16 bpp. wr_rise: write color base in the edge cycle.
  task automatic run_frame(logic [1:0] mode, int npix, int dens, string tag,
                           bit wr_rise, bit mid_wr);
    step(0, 0, 1, 2'd0, {22'h0, mode});
    cur_tag = tag;
    step(1, 0, wr_rise, 2'd2, 24'($urandom));
    step(1, 0, 0, 2'd0, '0);
    step(1, 0, 0, 2'd0, '0);
    for (int i = 0; i < 18; i++) step(0, 0, 0, 2'd0, '0);
    while (k < npix) begin
      if (mid_wr && ($urandom % 40) == 0)
        step(0, ($urandom % 100) < dens, 1, 2'(1 + $urandom % 3), 24'($urandom));
      else
        step(0, ($urandom % 100) < dens, 0, 2'd0, '0);
    end
  endtask

  initial begin
    void'($urandom(32'h1F2E_3D4C));
    for (int i = 0; i < LAT; i++) begin pipe_v[i] = 0; pipe_a[i] = '0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    for (int i = 0; i < 6; i++) step(0, 1, 0, 2'd0, '0);   // R1: pix_en ignored
    step(0, 0, 1, 2'd1, 24'h01_2345);
    step(0, 0, 1, 2'd2, 24'h40_0008);
    run_frame(2'b00, 1200, 70, "R4", 0, 1);
    run_frame(2'b01, 1200, 60, "R5", 0, 1);
    run_frame(2'b11, 800, 55, "R6", 0, 1);
    run_frame(2'b00, 300, 12, "R10", 0, 0);
    run_frame(2'b01, 700, 50, "R3", 1, 1);
    step(0, 0, 1, 2'd3, 24'hFF_FFFF);
    run_frame(2'b11, 700, 50, "R11", 0, 0);
    run_frame(2'b01, 200, 60, "R9", 0, 1);
    run_frame(2'b10, 600, 60, "R9", 0, 1);
    for (int f = 0; f < 10; f++)
      run_frame(2'($urandom % 4), 300 + $urandom % 600, 20 + $urandom % 40, "R8", $urandom % 2, 1);
    for (int i = 0; i < 8; i++) step(0, 0, 0, 2'd0, '0);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual running expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule